// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12). The field is held as a quadratic extension over GF(2^6). Each operand splits into a 6-bit upper half and a 6-bit lower half, and the result is assembled from GF(64) sub-products. A textbook single-polynomial GF(2^12) multiplier therefore gives different answers, and it cannot stand in for this one. The base field is GF(2)[x]/(x^6+x+1). The extension polynomial is y^2 + y + A^-1, which makes the lower half of the result take the upper sub-product scaled by 0x21.

A mode input switches the datapath to a generator step. In that mode the first operand is multiplied by the fixed element 0xE01, and a zero input produces 1 rather than 0. Repeating the step walks the power table used for syndrome work. The pipeline has two stages and accepts one operation per clock, with a valid flag carried alongside the data. Separately from the pipeline, a purely combinational path splits a 32-bit syndrome word into its two packed 12-bit syndromes.

Top module: `gf4096_tower_mul`

## Requirements
- R1: When both operands have a zero upper half (bits [11:6]), the product has a zero upper half. Its lower half is the GF(64) product of the lower halves, reduced by x^6 = x + 1 (for example 0x002 times 0x020 gives 0x003).
- R2: With mode = 0, the product of a and b is P = (H << 6) XOR L. Here H = (ah^al)*(bh^bl) XOR al*bl and L = (ah*bh)*0x21 XOR al*bl, with all sub-products taken in GF(64).
- R3: With mode = 1, the result is op_a times 0xE01 under the R2 rule, and op_b has no effect.
- R4: With mode = 1 and op_a = 0, the result is 0x001.
- R5: With mode = 0 and either operand equal to 0, the result is 0x000.
- R6: With mode = 0, the element 0x001 is the multiplicative identity: op_a times 0x001 equals op_a.
- R7: out_valid goes high exactly two clock edges after each cycle in which in_valid is high, and low two edges after each cycle in which in_valid is low. Back-to-back inputs yield back-to-back results.
- R8: While out_valid is low, out_prod keeps the last result produced.
- R9: syn_lo equals syn_word[11:0] and syn_hi equals syn_word[27:16], combinationally. Bits [15:12] and [31:28] have no effect on either output.
- R10: While rst_n is low, out_valid is 0 and out_prod is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0: general a*b; 1: generator step on op_a |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand (ignored when mode = 1) |
| syn_word | input | 32 | Packed syndrome pair |
| out_valid | output | 1 | out_prod carries a new result |
| out_prod | output | 12 | Product, held between results |
| syn_lo | output | 12 | Syndrome from bits [11:0] |
| syn_hi | output | 12 | Syndrome from bits [27:16] |

## Verification
Operands with only the lower half set exercise the GF(64) reduction on its own. A fixed vector (0x002 times 0x020 giving 0x003) catches a wrong reduction constant. Random full-width operands in both modes are compared against a reference built on carry-less multiplication followed by reduction. That comparison separates the tower combination, including the 0x21 scale, from a plain polynomial-basis product. Directed zero, identity and generator-zero inputs, together with random gaps in in_valid, check the special-case paths, the two-cycle latency and the holding of the output. Syndrome words with noise in their unused nibbles show whether the unpack picks the right bit fields.

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul #(
  parameter logic [11:0] GEN_K     = 12'hE01,
  parameter logic [5:0]  LOW_SCALE = 6'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        mode,
  input  logic [11:0] op_a,
  input  logic [11:0] op_b,
  input  logic [31:0] syn_word,
  output logic        out_valid,
  output logic [11:0] out_prod,
  output logic [11:0] syn_lo,
  output logic [11:0] syn_hi
);

  function automatic logic [5:0] gf64_mul(input logic [5:0] x, input logic [5:0] y);
    logic [6:0] sh;
    logic [5:0] xs;
    logic [5:0] acc;
    acc = '0;
    sh  = {1'b0, y};
    xs  = x;
    for (int i = 0; i < 6; i++) begin
      if (xs[0]) acc ^= sh[5:0];
      xs = xs >> 1;
      sh = sh << 1;
      if (sh[6]) sh ^= 7'h43;
    end
    return acc;
  endfunction

  logic [11:0] b_eff;
  logic [5:0]  ah, al, bh, bl;
  assign b_eff = mode ? GEN_K : op_b;
  assign ah = op_a[11:6];
  assign al = op_a[5:0];
  assign bh = b_eff[11:6];
  assign bl = b_eff[5:0];

  logic       v1, z1;
  logic [5:0] p_mid, p_lo, p_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      z1    <= 1'b0;
      p_mid <= '0;
      p_lo  <= '0;
      p_hi  <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        z1    <= mode && (op_a == 12'h000);
        p_mid <= gf64_mul(ah ^ al, bh ^ bl);
        p_lo  <= gf64_mul(al, bl);
        p_hi  <= gf64_mul(ah, bh);
      end
    end
  end

  logic [5:0] r_hi, r_lo;
  assign r_hi = p_mid ^ p_lo;
  assign r_lo = gf64_mul(p_hi, LOW_SCALE) ^ p_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_prod <= z1 ? 12'h001 : {r_hi, r_lo};
    end
  end

  assign syn_lo = syn_word[11:0];
  assign syn_hi = syn_word[27:16];

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##2 out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |-> ##2 !out_valid); // R7
  AST_HOLD_PROD: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_prod)); // R8
  AST_GEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mode && op_a == 12'h000) |-> ##2 (out_prod == 12'h001)); // R4
  AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && (op_a == 12'h000 || op_b == 12'h000)) |-> ##2 (out_prod == 12'h000)); // R5
  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !mode && op_b == 12'h001) |-> ##2 (out_prod == $past(op_a, 2))); // R6
  AST_RESET_OUT: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_prod == 12'h000)); // R10

endmodule

// File: tb/gf4096_tower_mul_tb.sv
`timescale 1ns/1ps
module gf4096_tower_mul_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, mode;
  logic [11:0] op_a, op_b;
  logic [31:0] syn_word;
  logic        out_valid;
  logic [11:0] out_prod, syn_lo, syn_hi;

  gf4096_tower_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .op_a(op_a), .op_b(op_b), .syn_word(syn_word),
    .out_valid(out_valid), .out_prod(out_prod), .syn_lo(syn_lo), .syn_hi(syn_hi)
  );

  int total = 0;
  int bad   = 0;

  function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] c;
    c = '0;
    for (int i = 0; i < 6; i++) if (y[i]) c ^= 11'(x) << i;
    for (int k = 10; k >= 6; k--) if (c[k]) c ^= 11'h43 << (k - 6);
    return c[5:0];
  endfunction

  function automatic logic [11:0] ref_tower(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] h, l, m;
    m = ref64(a[5:0], b[5:0]);
    h = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m;
    l = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ m;
    return {h, l};
  endfunction

  function automatic logic [11:0] ref_op(input logic md, input logic [11:0] a, input logic [11:0] b);
    if (md) return (a == 12'h000) ? 12'h001 : ref_tower(a, 12'hE01);
    return ref_tower(a, b);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic        h0_v = 1'b0, h1_v = 1'b0;
  logic [11:0] h0_e = '0, h1_e = '0, last_e = '0;
  string       h0_t = "R2", h1_t = "R2";

  task automatic step(input logic v, input logic md, input logic [11:0] a, input logic [11:0] b,
                      input logic [11:0] exp, input string tag);
    @(negedge clk);
    chk("R7 out_valid", {31'b0, out_valid}, {31'b0, h1_v});
    if (h1_v) begin
      chk(h1_t, {20'b0, out_prod}, {20'b0, h1_e});
      last_e = h1_e;
    end else begin
      chk("R8 hold", {20'b0, out_prod}, {20'b0, last_e});
    end
    h1_v = h0_v; h1_e = h0_e; h1_t = h0_t;
    h0_v = v;    h0_e = exp;  h0_t = tag;
    in_valid = v; mode = md; op_a = a; op_b = b;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] a, b;
    logic v, md;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; op_a = '0; op_b = '0; syn_word = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10 out_prod", {20'b0, out_prod}, 32'd0);
    rst_n = 1'b1;

    step(1, 0, 12'h002, 12'h020, 12'h003, "R1 x*x^5");
    step(1, 0, 12'h03F, 12'h03F, ref64(6'h3F, 6'h3F), "R1 low-only");
    step(1, 0, 12'h000, 12'hABC, 12'h000, "R5 a zero");
    step(1, 0, 12'h7D3, 12'h000, 12'h000, "R5 b zero");
    step(1, 0, 12'h9A5, 12'h001, 12'h9A5, "R6 identity");
    step(1, 0, 12'h001, 12'hFFF, 12'hFFF, "R6 identity swap");
    step(1, 1, 12'h000, 12'h123, 12'h001, "R4 gen zero");
    step(1, 1, 12'h001, 12'h456, 12'hE01, "R3 gen of one");
    step(1, 1, 12'h5A5, 12'hFFF, ref_op(1, 12'h5A5, 12'h000), "R3 b ignored");
    step(0, 0, 12'hFFF, 12'hFFF, 12'h000, "R8");
    step(0, 1, 12'h000, 12'h000, 12'h000, "R8");
    step(1, 0, 12'hFC0, 12'hFC0, ref_tower(12'hFC0, 12'hFC0), "R2 high-only");
    for (int i = 0; i < 64; i++) begin
      a = 12'(i);
      b = 12'(($urandom % 64));
      step(1, 0, a, b, ref64(a[5:0], b[5:0]), "R1 sweep");
    end
    for (int i = 0; i < 2000; i++) begin
      v  = ($urandom % 4) != 0;
      md = $urandom % 2;
      a  = 12'($urandom);
      b  = 12'($urandom);
      if (($urandom % 16) == 0) a = 12'h000;
      step(v, md, a, b, ref_op(md, a, b), md ? "R3 random" : "R2 random");
    end
    step(0, 0, 12'h000, 12'h000, 12'h000, "R8");
    step(0, 0, 12'h000, 12'h000, 12'h000, "R8");
    step(0, 0, 12'h000, 12'h000, 12'h000, "R8");

    for (int i = 0; i < 20; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i == 0) w = 32'hF000_F000;
      if (i == 1) w = 32'h0ABC_0123;
      @(negedge clk);
      syn_word = w;
      #1;
      chk("R9 syn_lo", {20'b0, syn_lo}, {20'b0, w[11:0]});
      chk("R9 syn_hi", {20'b0, syn_hi}, {20'b0, w[27:16]});
    end

    summary();
    $finish;
  end
endmodule